// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the control core of a byte-wide NOR flash array, written as a synchronous behavioural model. Writes on the bus are not stored directly. They are matched step by step against multi-write unlock sequences, and each sequence ends in a command:

- program one byte;
- erase the whole array;
- lock the boot region for good;
- enter or leave the identification mode.

Program and erase run for a fixed number of clock cycles counted inside the block. While one of them runs, every read returns a status word instead of array data. The write that completes a command is the final write of its sequence.

The array is scaled down for simulation. It holds `2**MEM_AW` bytes (1024 by default) and is indexed by the low `MEM_AW` address bits. Bus addresses keep their full `ADDR_W` width (17 by default). The boot region is every address below `2**BOOT_AW` (128 bytes by default). Program time is `PROG_CYC` clock cycles and erase time is `ERASE_CYC` clock cycles. Reset clears the lock and the identification mode but not the array contents, so the first step after reset is an erase.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The writes AA@5555, 55@2AAA, A0@5555 followed by one write of data D to address X start a program. When the program completes, the byte at X becomes its old value ANDed with D, so program can clear bits but never set them.
- R2: `busy` rises in the cycle after the final write of a program or erase. It stays high for exactly `PROG_CYC` cycles for a program and exactly `ERASE_CYC` cycles for an erase. It never rises without such a write.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 start an erase. When the erase completes, every byte outside a locked boot region reads FF.
- R4: A read issued while `busy` is high returns a status word with three parts:
  - bit 7 is the complement of bit 7 of the data in the final write of the running command;
  - bit 6 is 0 on the first read after the command starts and flips on every further read;
  - bits 5:0 are 0.
  Once the command completes, reads return array data again.
- R5: Writes made while `busy` is high are ignored. They neither advance a sequence nor start a command.
- R6: A write that does not match the expected step returns the interpreter to its idle state and changes nothing. Only a new write of AA to 5555 can then begin a sequence.
- R7: Command steps compare only address bits 14:0, so address bits above bit 14 have no effect on a command step.
- R8: The writes AA@5555, 55@2AAA, 90@5555 enter the identification mode. In that mode a read of address 2 returns the lock flag in bit 0 (1 means locked) with bits 7:1 at 0. A read of any other address returns 1F when address bit 0 is 0 and 17 when it is 1.
- R9: Either of two writes leaves the identification mode:
  - one write of F0 to any address while the interpreter is idle;
  - the writes AA@5555, 55@2AAA, F0@5555.
  After that, reads return array data again.
- R10: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 40@5555 set the lock flag. No command clears it; only reset does. Once it is set:
  - a program aimed below `2**BOOT_AW` is dropped, with no busy period and no change to the byte;
  - an erase leaves the bytes below `2**BOOT_AW` unchanged;
  - addresses at or above `2**BOOT_AW` remain programmable.
- R11: Each cycle with `rd_en` high produces `rd_valid` high with the read result on `rd_data` in the following cycle. After reset, `busy` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result: array byte, status word or identification value |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| busy | output | 1 | A program or erase is running |

## Verification
A sequence state that is stuck or wrong shows up as a missing or spurious `busy` rise in the cycle after the write that should end a command. It may also show up later, as an unchanged or changed byte on the next read of the target address. A wrong cycle count appears as a `busy` period that is too short or too long. A wrong lock or boot-range decision appears when a boot address is read back after a program or erase. Read-path mix-ups among status, identification and array data are visible on the very next `rd_data`. The bench therefore reads back every affected address right after each command completes, and also reads a sample of addresses that must be unaffected.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMD_AW = 15;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_A      = 8'hAA;
    localparam logic [7:0] KEY_B      = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_SETUP  = 8'h80;
    localparam logic [7:0] CMD_ERASE  = 8'h10;
    localparam logic [7:0] CMD_LOCK   = 8'h40;
    localparam logic [7:0] CMD_ID_IN  = 8'h90;
    localparam logic [7:0] CMD_ID_OUT = 8'hF0;

    localparam logic [7:0] ID_MAKER = 8'h1F;
    localparam logic [7:0] ID_PART  = 8'h17;
    localparam logic [7:0] ERASED   = 8'hFF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG,
        SQ_EKEY0,
        SQ_EKEY1,
        SQ_EKEY2
    } seq_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE,
        OP_LOCK,
        OP_ID_IN,
        OP_ID_OUT
    } op_t;

    function automatic logic step_hit(
        input logic [CMD_AW-1:0] a,
        input logic [7:0]        d,
        input logic [CMD_AW-1:0] ea,
        input logic [7:0]        ed
    );
        return (a == ea) && (d == ed);
    endfunction

    function automatic logic [7:0] poll_word(input logic [7:0] last, input logic tog);
        return {~last[7], tog, 6'b000000};
    endfunction

    function automatic logic [7:0] id_word(input logic odd);
        return odd ? ID_PART : ID_MAKER;
    endfunction

    function automatic logic is_timed(input op_t k);
        return (k == OP_PROG) || (k == OP_ERASE);
    endfunction

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int BOOT_AW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic              id_mode,
    input  logic              locked,
    output op_t               op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);

    seq_t              seq_q, seq_d;
    logic [CMD_AW-1:0] low;
    logic              go;
    logic              boot_hit;
    logic              hit_a_key, hit_b_key;

    assign low       = wr_addr[CMD_AW-1:0];
    assign go        = wr_en && !busy;
    assign boot_hit  = (wr_addr >> BOOT_AW) == '0;
    assign hit_a_key = step_hit(low, wr_data, KEY_ADDR_A, KEY_A);
    assign hit_b_key = step_hit(low, wr_data, KEY_ADDR_B, KEY_B);
    assign op_addr   = wr_addr;
    assign op_data   = wr_data;

    always_comb begin
        seq_d   = seq_q;
        op_kind = OP_NONE;
        if (go) begin
            seq_d = SQ_IDLE;
            unique case (seq_q)
                SQ_IDLE: begin
                    if (hit_a_key) begin
                        seq_d = SQ_KEY1;
                    end else if (id_mode && wr_data == CMD_ID_OUT) begin
                        op_kind = OP_ID_OUT;
                    end
                end
                SQ_KEY1: begin
                    if (hit_b_key) seq_d = SQ_KEY2;
                end
                SQ_KEY2: begin
                    if (step_hit(low, wr_data, KEY_ADDR_A, CMD_PROG)) begin
                        seq_d = SQ_PROG;
                    end else if (step_hit(low, wr_data, KEY_ADDR_A, CMD_SETUP)) begin
                        seq_d = SQ_EKEY0;
                    end else if (step_hit(low, wr_data, KEY_ADDR_A, CMD_ID_IN)) begin
                        op_kind = OP_ID_IN;
                    end else if (step_hit(low, wr_data, KEY_ADDR_A, CMD_ID_OUT)) begin
                        op_kind = OP_ID_OUT;
                    end
                end
                SQ_PROG: begin
                    if (!(locked && boot_hit)) op_kind = OP_PROG;
                end
                SQ_EKEY0: begin
                    if (hit_a_key) seq_d = SQ_EKEY1;
                end
                SQ_EKEY1: begin
                    if (hit_b_key) seq_d = SQ_EKEY2;
                end
                SQ_EKEY2: begin
                    if (step_hit(low, wr_data, KEY_ADDR_A, CMD_ERASE)) begin
                        op_kind = OP_ERASE;
                    end else if (step_hit(low, wr_data, KEY_ADDR_A, CMD_LOCK)) begin
                        op_kind = OP_LOCK;
                    end
                end
                default: seq_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_SEQ_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(seq_q)); // R5

    AST_CMD_ENDS_SEQ: assert property (@(posedge clk) disable iff (rst)
        (op_kind != OP_NONE) |=> (seq_q == SQ_IDLE)); // R6

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int PROG_CYC  = 12,
    parameter int ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  op_t               op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    output logic              busy,
    output logic              finish,
    output op_t               run_kind,
    output logic [ADDR_W-1:0] run_addr,
    output logic [7:0]        run_data
);

    localparam int LONGEST = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             start;

    assign start  = is_timed(op_kind);
    assign finish = busy_q && (cnt_q == '0);
    assign busy   = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            run_kind <= OP_NONE;
            run_addr <= '0;
            run_data <= '0;
        end else if (start) begin
            busy_q   <= 1'b1;
            cnt_q    <= (op_kind == OP_PROG) ? PROG_LAST : ERASE_LAST;
            run_kind <= op_kind;
            run_addr <= op_addr;
            run_data <= op_data;
        end else if (finish) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q); // R5

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= ((run_kind == OP_PROG) ? PROG_LAST : ERASE_LAST))); // R2

endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_cmd_pkg::*;
#(
    parameter int MEM_AW  = 10,
    parameter int BOOT_AW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_prog,
    input  logic              commit_erase,
    input  logic              set_lock,
    input  logic [MEM_AW-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [7:0]        rd_word,
    output logic              locked
);

    localparam int DEPTH     = 1 << MEM_AW;
    localparam int BOOT_SIZE = 1 << BOOT_AW;

    logic [7:0] mem [DEPTH];
    logic       locked_q;

    always_ff @(posedge clk) begin
        if (commit_erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!(locked_q && (i < BOOT_SIZE))) mem[i] <= ERASED;
            end
        end else if (commit_prog) begin
            mem[wr_idx] <= mem[wr_idx] & wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
        end else if (set_lock) begin
            locked_q <= 1'b1;
        end
    end

    assign rd_word = mem[rd_idx];
    assign locked  = locked_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q); // R10

    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !(commit_prog && commit_erase)); // R3

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int MEM_AW    = 10,
    parameter int BOOT_AW   = 7,
    parameter int PROG_CYC  = 12,
    parameter int ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] LOCK_INFO_ADDR = ADDR_W'(2);

    op_t               op_kind, run_kind;
    logic [ADDR_W-1:0] op_addr, run_addr;
    logic [7:0]        op_data, run_data;
    logic              finish, locked;
    logic              commit_prog, commit_erase;
    logic [7:0]        rd_word;
    logic              id_mode_q, tog_q;
    logic              op_starts;

    flash_cmd_decoder #(
        .ADDR_W  (ADDR_W),
        .BOOT_AW (BOOT_AW)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy),
        .id_mode (id_mode_q),
        .locked  (locked),
        .op_kind (op_kind),
        .op_addr (op_addr),
        .op_data (op_data)
    );

    flash_op_timer #(
        .ADDR_W    (ADDR_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .op_kind  (op_kind),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .busy     (busy),
        .finish   (finish),
        .run_kind (run_kind),
        .run_addr (run_addr),
        .run_data (run_data)
    );

    assign commit_prog  = finish && (run_kind == OP_PROG);
    assign commit_erase = finish && (run_kind == OP_ERASE);
    assign op_starts    = is_timed(op_kind);

    flash_store #(
        .MEM_AW  (MEM_AW),
        .BOOT_AW (BOOT_AW)
    ) u_store (
        .clk          (clk),
        .rst          (rst),
        .commit_prog  (commit_prog),
        .commit_erase (commit_erase),
        .set_lock     (op_kind == OP_LOCK),
        .wr_idx       (run_addr[MEM_AW-1:0]),
        .wr_data      (run_data),
        .rd_idx       (rd_addr[MEM_AW-1:0]),
        .rd_word      (rd_word),
        .locked       (locked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            id_mode_q <= 1'b0;
        end else if (op_kind == OP_ID_IN) begin
            id_mode_q <= 1'b1;
        end else if (op_kind == OP_ID_OUT) begin
            id_mode_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= 1'b0;
        end else if (op_starts) begin
            tog_q <= 1'b0;
        end else if (rd_en && busy) begin
            tog_q <= ~tog_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                if (busy) begin
                    rd_data <= poll_word(run_data, tog_q);
                end else if (id_mode_q) begin
                    rd_data <= (rd_addr == LOCK_INFO_ADDR) ? {7'b0000000, locked}
                                                           : id_word(rd_addr[0]);
                end else begin
                    rd_data <= rd_word;
                end
            end
        end
    end

    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R11

    AST_POLL_MSB: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> (rd_data[7] == ~$past(run_data[7]))); // R4

    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(op_starts)); // R2

    AST_NO_BOOT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit_prog |-> !(locked && ((run_addr >> BOOT_AW) == '0))); // R10

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;

    localparam int AW   = 17;
    localparam int MAW  = 10;
    localparam int BAW  = 7;
    localparam int PCYC = 12;
    localparam int ECYC = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          rd_valid;
    logic          busy;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W    (AW),
        .MEM_AW    (MAW),
        .BOOT_AW   (BAW),
        .PROG_CYC  (PCYC),
        .ERASE_CYC (ECYC)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .busy     (busy)
    );

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t sb_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   ended = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R11 unexpected rd_valid", rd_data, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rd_data === e.val, e.req, rd_data, e.val);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string req);
        exp_t x;
        x.val = e; x.req = req;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        sb_q.push_back(x);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
        unlock();
        wr(17'h05555, 8'hA0);
        wr(a, d);
    endtask

    task automatic six_step(input logic [7:0] last);
        unlock();
        wr(17'h05555, 8'h80);
        unlock();
        wr(17'h05555, last);
    endtask

    task automatic id_enter();
        unlock();
        wr(17'h05555, 8'h90);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R11 reset busy low", busy, 0);
        check(rd_valid == 1'b0, "R11 reset rd_valid low", rd_valid, 0);

        // first erase and its length
        six_step(8'h10);
        busy_len(n);
        check(n == ECYC, "R2 erase busy length", n, ECYC);
        rd(17'h00010, 8'hFF, "R3 erased boot byte");
        rd(17'h003FF, 8'hFF, "R3 erased top byte");

        // program with status polling
        program_byte(17'h00300, 8'h3C);
        rd(17'h00300, 8'h80, "R4 first poll");
        rd(17'h00300, 8'hC0, "R4 second poll");
        wait_idle();
        rd(17'h00300, 8'h3C, "R1 programmed");

        // AND behaviour and program length
        program_byte(17'h00300, 8'hF0);
        busy_len(n);
        check(n == PCYC, "R2 program busy length", n, PCYC);
        rd(17'h00300, 8'h30, "R1 AND result");

        program_byte(17'h00010, 8'h5A);
        wait_idle();
        rd(17'h00010, 8'h5A, "R10 boot programmable before lock");

        // writes during busy
        program_byte(17'h00301, 8'h00);
        program_byte(17'h00302, 8'h00);
        wait_idle();
        @(negedge clk);
        check(busy == 1'b0, "R5 no second busy", busy, 0);
        rd(17'h00302, 8'hFF, "R5 write during busy ignored");
        rd(17'h00301, 8'h00, "R5 first program done");

        // broken sequence
        unlock();
        wr(17'h01234, 8'hA0);
        wr(17'h00303, 8'h00);
        check(busy == 1'b0, "R6 broken sequence no busy", busy, 0);
        rd(17'h00303, 8'hFF, "R6 byte unchanged");
        program_byte(17'h00303, 8'h81);
        wait_idle();
        rd(17'h00303, 8'h81, "R6 recovery program");

        // high address bits ignored on command steps
        wr(17'h15555, 8'hAA);
        wr(17'h12AAA, 8'h55);
        wr(17'h1D555, 8'hA0);
        wr(17'h00304, 8'h42);
        check(busy == 1'b1, "R7 aliased command starts", busy, 1);
        wait_idle();
        rd(17'h00304, 8'h42, "R7 aliased program");

        // identification mode
        id_enter();
        rd(17'h00000, 8'h1F, "R8 maker code");
        rd(17'h00001, 8'h17, "R8 part code");
        rd(17'h00002, 8'h00, "R8 lock clear");
        rd(17'h00303, 8'h17, "R8 odd address code");
        wr(17'h00777, 8'hF0);
        rd(17'h00300, 8'h30, "R9 single F0 exit");
        id_enter();
        rd(17'h00002, 8'h00, "R8 lock clear again");
        unlock();
        wr(17'h05555, 8'hF0);
        rd(17'h00301, 8'h00, "R9 long exit");

        // boot lock
        six_step(8'h40);
        check(busy == 1'b0, "R10 lock not timed", busy, 0);
        id_enter();
        rd(17'h00002, 8'h01, "R10 lock reported");
        wr(17'h00000, 8'hF0);
        program_byte(17'h00010, 8'h00);
        check(busy == 1'b0, "R10 boot program dropped", busy, 0);
        rd(17'h00010, 8'h5A, "R10 boot byte kept");
        program_byte(17'h0007F, 8'h00);
        check(busy == 1'b0, "R10 boot top dropped", busy, 0);
        rd(17'h0007F, 8'hFF, "R10 boot top kept");
        program_byte(17'h00080, 8'h11);
        wait_idle();
        rd(17'h00080, 8'h11, "R10 main still programmable");

        // erase with lock
        six_step(8'h10);
        rd(17'h00080, 8'h80, "R4 erase first poll");
        rd(17'h00080, 8'hC0, "R4 erase second poll");
        wait_idle();
        rd(17'h00010, 8'h5A, "R10 erase keeps boot");
        rd(17'h0007F, 8'hFF, "R10 erase keeps boot top");
        rd(17'h00300, 8'hFF, "R3 erase main");
        rd(17'h00080, 8'hFF, "R3 erase main boundary");
        id_enter();
        rd(17'h00002, 8'h01, "R10 lock sticky");
        wr(17'h00000, 8'hF0);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R11 all reads answered", sb_q.size(), 0);
        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule